// File: doc/BRIEF.md
# Double-Buffered Multichannel DAC Update Controller

This block is the register side of a bank of digital-to-analog converter channels. Each channel holds two 12-bit stages. A staging latch receives host writes. A presented latch drives the converter code. A host reaches the block over a 16-bit word bus with an active-low select and a direction line. It can write channel codes and issue three data-less commands. Two commands pick the update policy, and the third is a global copy trigger. The host can also read per-channel calibration bytes from a fixed internal table.

There are two policies. In pass-through mode a channel write reaches that channel's presented latch at once. In staged mode writes collect in the staging latches, and one trigger moves every channel together. Reset returns every presented code to mid-scale and selects staged mode. Reset leaves the staging latches untouched, so whatever they hold appears on the next pass-through select or trigger. Every supported access is acknowledged one cycle after it is sampled, with no wait states.

Top module: `dac_update_ctrl`

## Requirements
- R1: A write to word address k (byte offset 2k, 0 ≤ k < 16) loads bits 15:4 of the write data into channel k's staging latch; bits 3:0 have no effect.
- R2: In pass-through mode a channel write also loads that channel's presented code on the same clock edge, and no other channel's code changes.
- R3: In staged mode a channel write leaves all presented codes unchanged. A write to word address 18 (byte 0x24, trigger) copies every staging latch into its presented latch on one edge.
- R4: A write to word address 16 (byte 0x20) selects pass-through mode and copies every staging latch into its presented latch. A write to word address 17 (byte 0x22) selects staged mode and leaves the presented codes as they are. The data value of all three commands is ignored.
- R5: A trigger write issued in pass-through mode switches the block to staged mode, so later channel writes no longer reach the presented codes.
- R6: Synchronous reset (rst_n low at an edge) sets every presented code to 0x800 and selects staged mode. The staging latches keep their contents, and a trigger after reset presents them.
- R7: A read of word address 32+2c returns channel c's offset byte (c*37+5) mod 256. A read of word 33+2c returns its gain byte (195 − c*9) mod 256. The byte appears on rdata[7:0] with rdata[15:8] zero, during the acknowledge cycle.
- R8: ack_n is low for exactly the cycle after each edge at which sel_n is low with a supported access, and high otherwise. rdata is zero whenever ack_n is high.
- R9: Word addresses 19 to 31, reads of word addresses 0 to 18, and writes to word addresses 32 to 63 get no acknowledge and change no presented code.
- R10: Back-to-back accesses on consecutive cycles are each acknowledged and each take effect (no wait states).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low access select, sampled each rising edge |
| rd_nwr | input | 1 | Access direction: 1 read, 0 write |
| waddr | input | 6 | Word address (byte offset divided by two) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid while ack_n is low |
| ack_n | output | 1 | Active-low single-cycle acknowledge |
| dac_code | output | 192 | Presented codes, channel k at bits [12k+11:12k] |

## Verification
The update policy is driven with mixed sequences: channel writes in staged mode, then a trigger; channel writes after a pass-through select; a staged-mode select part way through; and a trigger issued while in pass-through mode. Comparing all 16 presented codes after every access tells a per-channel update apart from a global copy, and either of those apart from no update. Write data with nonzero low nibbles shows that bits 3:0 are dropped. A reset in the middle of the run, followed by a trigger, separates a cleared staging latch from one that was kept. Reads over the whole calibration window, the unused gap, reads of the write space and writes to the read window tell a correct decode apart from one that leaks acknowledges.

// File: rtl/dac_upd_pkg.sv
// Package: shared constants, mode type and calibration table function for
// the DAC update controller. Assumes word addressing on the host bus.
package dac_upd_pkg;

    typedef enum logic {
        MODE_STAGED = 1'b0,
        MODE_PASS   = 1'b1
    } upd_mode_t;

    localparam int CMD_PASS_ADDR   = 16;
    localparam int CMD_STAGED_ADDR = 17;
    localparam int CMD_TRIG_ADDR   = 18;
    localparam int CAL_BASE_ADDR   = 32;
    localparam logic [11:0] MID_CODE = 12'h800;

    // Calibration byte for channel ch; gain_sel picks gain over offset.
    function automatic logic [7:0] cal_byte(input int ch, input logic gain_sel);
        int v;
        if (gain_sel) v = 195 - ch * 9;
        else          v = ch * 37 + 5;
        return 8'(v & 255);
    endfunction

endpackage

// File: rtl/dac_bus_decode.sv
// Bus decoder: turns one sampled access into one-hot strobes for channel
// writes, the three commands and the calibration read window.
// Assumes NCH <= 16 so channel words never overlap the command words.
module dac_bus_decode
    import dac_upd_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int ADDR_W = 6
) (
    input  logic              sel_n,
    input  logic              rd_nwr,
    input  logic [ADDR_W-1:0] waddr,
    output logic [NCH-1:0]    chan_we,
    output logic              cmd_pass,
    output logic              cmd_staged,
    output logic              cmd_trig,
    output logic              cal_rd,
    output logic              hit
);
    localparam int CAL_END = CAL_BASE_ADDR + 2 * NCH;

    logic wr_acc;
    logic rd_acc;
    int   a;

    assign wr_acc = !sel_n && !rd_nwr;
    assign rd_acc = !sel_n &&  rd_nwr;
    assign a      = int'(waddr);

    // Per-channel write strobes
    generate
        for (genvar k = 0; k < NCH; k++) begin : g_we
            assign chan_we[k] = wr_acc && (a == k);
        end
    endgenerate

    // Command and read-window strobes
    always_comb begin
        cmd_pass   = wr_acc && (a == CMD_PASS_ADDR);
        cmd_staged = wr_acc && (a == CMD_STAGED_ADDR);
        cmd_trig   = wr_acc && (a == CMD_TRIG_ADDR);
        cal_rd     = rd_acc && (a >= CAL_BASE_ADDR) && (a < CAL_END);
        hit        = (|chan_we) || cmd_pass || cmd_staged || cmd_trig || cal_rd;
    end

endmodule

// File: rtl/dac_chan_latch.sv
// One channel's two-stage latch. The staging stage has no reset on purpose:
// its contents survive reset. The presented stage resets to mid-scale.
module dac_chan_latch
    import dac_upd_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CODE_W-1:0] wcode,
    input  logic              load_all,
    input  logic              pass_mode,
    output logic [CODE_W-1:0] code_out
);
    logic [CODE_W-1:0] stage_q;
    logic [CODE_W-1:0] pres_q;

    // Staging latch: captures host data, untouched by reset
    always_ff @(posedge clk) begin
        if (we) stage_q <= wcode;
    end

    // Presented latch: mid-scale on reset, global copy or pass-through load
    always_ff @(posedge clk) begin
        if (!rst_n)                pres_q <= CODE_W'(MID_CODE);
        else if (load_all)         pres_q <= stage_q;
        else if (we && pass_mode)  pres_q <= wcode;
    end

    assign code_out = pres_q;

endmodule

// File: rtl/dac_cal_rom.sv
// Calibration table: combinational lookup of a byte by word address.
// Addresses outside the window return zero.
module dac_cal_rom
    import dac_upd_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] waddr,
    output logic [7:0]        cal_out
);
    localparam int ENTRIES = 2 * NCH;

    logic [7:0] table_q [ENTRIES];

    // Table contents computed per entry
    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
            assign table_q[e] = cal_byte(e / 2, (e % 2) == 1);
        end
    endgenerate

    // Index select
    always_comb begin
        int idx;
        idx = int'(waddr) - CAL_BASE_ADDR;
        cal_out = 8'h00;
        if (idx >= 0 && idx < ENTRIES) cal_out = table_q[idx];
    end

endmodule

// File: rtl/dac_update_ctrl.sv
// Top: bus slave and update controller for NCH double-buffered DAC
// channels. One access may be sampled per clock; the acknowledge and read
// data are registered and appear in the following cycle.
module dac_update_ctrl
    import dac_upd_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int CODE_W = 12,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_n,
    input  logic                  rd_nwr,
    input  logic [ADDR_W-1:0]     waddr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output logic                  ack_n,
    output logic [NCH*CODE_W-1:0] dac_code
);
    localparam int LSB_DROP = DATA_W - CODE_W;

    logic [NCH-1:0]    chan_we;
    logic              cmd_pass;
    logic              cmd_staged;
    logic              cmd_trig;
    logic              cal_rd;
    logic              hit;
    logic [7:0]        cal_byte_w;
    logic [CODE_W-1:0] wcode;
    logic              load_all;
    upd_mode_t         mode_q;
    logic              ack_n_q;
    logic [DATA_W-1:0] rdata_q;
    wire               unused_low = ^wdata[LSB_DROP-1:0];

    assign wcode    = wdata[DATA_W-1:LSB_DROP];
    assign load_all = cmd_pass || cmd_trig;

    dac_bus_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
        .sel_n      (sel_n),
        .rd_nwr     (rd_nwr),
        .waddr      (waddr),
        .chan_we    (chan_we),
        .cmd_pass   (cmd_pass),
        .cmd_staged (cmd_staged),
        .cmd_trig   (cmd_trig),
        .cal_rd     (cal_rd),
        .hit        (hit)
    );

    dac_cal_rom #(.NCH(NCH), .ADDR_W(ADDR_W)) u_cal (
        .waddr   (waddr),
        .cal_out (cal_byte_w)
    );

    // Update policy register: staged after reset, trigger forces staged
    always_ff @(posedge clk) begin
        if (!rst_n)                     mode_q <= MODE_STAGED;
        else if (cmd_pass)              mode_q <= MODE_PASS;
        else if (cmd_staged || cmd_trig) mode_q <= MODE_STAGED;
    end

    // Zero-wait acknowledge and read data, one cycle after sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_n_q <= 1'b1;
            rdata_q <= '0;
        end else begin
            ack_n_q <= !hit;
            rdata_q <= cal_rd ? DATA_W'(cal_byte_w) : '0;
        end
    end

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_ch
            dac_chan_latch #(.CODE_W(CODE_W)) u_lat (
                .clk       (clk),
                .rst_n     (rst_n),
                .we        (chan_we[k]),
                .wcode     (wcode),
                .load_all  (load_all),
                .pass_mode (mode_q == MODE_PASS),
                .code_out  (dac_code[k*CODE_W +: CODE_W])
            );
        end
    endgenerate

    assign ack_n = ack_n_q;
    assign rdata = rdata_q;

endmodule

// File: rtl/dac_update_chk.sv
// Checker: port-level properties of the DAC update controller, bound to
// every instance of the top module.
module dac_update_chk #(
    parameter int NCH    = 16,
    parameter int CODE_W = 12,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sel_n,
    input logic                  rd_nwr,
    input logic [ADDR_W-1:0]     waddr,
    input logic [DATA_W-1:0]     wdata,
    input logic [DATA_W-1:0]     rdata,
    input logic                  ack_n,
    input logic [NCH*CODE_W-1:0] dac_code
);
    localparam int CAL_END = 32 + 2 * NCH;
    wire unused_wd = ^wdata;

    // R6: reset drives every presented code to mid-scale
    a_r6_reset_mid: assert property (@(posedge clk)
        !rst_n |=> dac_code == {NCH{CODE_W'(12'h800)}});

    // R8: no select, no acknowledge next cycle
    a_r8_idle_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> ack_n);

    // R8: read data quiet outside acknowledge
    a_r8_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ack_n |-> rdata == '0);

    // R7: upper byte of read data always zero
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:8] == '0);

    // R9: unused gap never acknowledged
    a_r9_gap_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && int'(waddr) >= 19 && int'(waddr) < 32) |=> ack_n);

    // R7, R10: calibration reads acknowledged in the next cycle
    a_r10_cal_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && rd_nwr && int'(waddr) >= 32 && int'(waddr) < CAL_END) |=> !ack_n);

    // R3: presented codes only move after a write access
    a_r3_codes_need_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(dac_code)) |-> $past(!sel_n && !rd_nwr));

endmodule

bind dac_update_ctrl dac_update_chk #(
    .NCH(NCH), .CODE_W(CODE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/dac_update_ctrl_bench.sv
// Bench: reference model built from the requirements, a vector table
// walked by one loop, then directed reset and decode corner cases.
module dac_update_ctrl_bench;
    localparam int NCH = 16;
    localparam int NV  = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1;
    logic          rd_nwr = 1'b0;
    logic [5:0]    waddr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic          ack_n;
    logic [191:0]  dac_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [11:0] m_in  [NCH];
    logic [11:0] m_out [NCH];
    bit          m_pass;

    // {rd, word address, data}
    localparam logic [22:0] VEC [NV] = '{
        {1'b0, 6'd3,  16'hABC5}, {1'b0, 6'd15, 16'h1234}, {1'b0, 6'd18, 16'hFFFF},
        {1'b0, 6'd16, 16'h0000}, {1'b0, 6'd0,  16'h7FF0}, {1'b0, 6'd9,  16'hFFFF},
        {1'b1, 6'd0,  16'h0000}, {1'b0, 6'd17, 16'h5A5A}, {1'b0, 6'd9,  16'h001F},
        {1'b1, 6'd34, 16'h0000}, {1'b0, 6'd20, 16'h1111}, {1'b0, 6'd40, 16'h2222},
        {1'b0, 6'd16, 16'hC3C3}, {1'b0, 6'd18, 16'h0000}, {1'b0, 6'd2,  16'h5558},
        {1'b1, 6'd63, 16'h0000}, {1'b0, 6'd18, 16'h0001}
    };

    dac_update_ctrl u_dac_update_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_nwr(rd_nwr),
        .waddr(waddr), .wdata(wdata), .rdata(rdata), .ack_n(ack_n),
        .dac_code(dac_code)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] exp_cal(input int a);
        int c = (a - 32) / 2;
        if ((a - 32) % 2 == 0) return 8'((c * 37 + 5) & 255);
        return 8'((195 - c * 9) & 255);
    endfunction

    function automatic logic [191:0] exp_codes();
        logic [191:0] v;
        for (int k = 0; k < NCH; k++) v[k*12 +: 12] = m_out[k];
        return v;
    endfunction

    task automatic check(input string tag, input logic [191:0] act, input logic [191:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access: drive at falling edge, sample at the next falling edge
    task automatic access(input logic rd, input int a, input logic [15:0] d, input string tag);
        logic       exp_ack;
        logic [15:0] exp_rd;
        exp_ack = 1'b0;
        exp_rd  = '0;
        sel_n = 1'b0; rd_nwr = rd; waddr = 6'(a); wdata = d;
        if (!rd) begin
            if (a < NCH) begin
                m_in[a] = d[15:4];
                if (m_pass) m_out[a] = d[15:4];
                exp_ack = 1'b1;
            end else if (a == 16) begin
                m_pass = 1; for (int k = 0; k < NCH; k++) m_out[k] = m_in[k]; exp_ack = 1'b1;
            end else if (a == 17) begin
                m_pass = 0; exp_ack = 1'b1;
            end else if (a == 18) begin
                m_pass = 0; for (int k = 0; k < NCH; k++) m_out[k] = m_in[k]; exp_ack = 1'b1;
            end
        end else if (a >= 32) begin
            exp_ack = 1'b1;
            exp_rd  = {8'h00, exp_cal(a)};
        end
        @(posedge clk);
        @(negedge clk);
        check({tag, " ack"}, 192'(ack_n), 192'(!exp_ack));
        check({tag, " rdata"}, 192'(rdata), 192'(exp_rd));
        check({tag, " codes"}, dac_code, exp_codes());
        sel_n = 1'b1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_pass = 0;
        for (int k = 0; k < NCH; k++) m_out[k] = 12'h800;
    endtask

    initial begin
        m_pass = 0;
        for (int k = 0; k < NCH; k++) begin m_out[k] = 12'h800; m_in[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R6: reset state at the ports
        check("R6 reset codes", dac_code, exp_codes());
        check("R8 reset ack", 192'(ack_n), 192'(1));
        check("R8 reset rdata", 192'(rdata), 192'(0));

        // R1, R3: preload every staging latch in staged mode, back to back (R10)
        for (int k = 0; k < NCH; k++)
            access(1'b0, k, 16'((k * 16'h0123 + 16'h0107) & 16'hFFFF), "R1/R3/R10 preload");

        // Table walk: R2, R3, R4, R5, R7, R9
        for (int i = 0; i < NV; i++)
            access(VEC[i][22], int'(VEC[i][21:16]), VEC[i][15:0], "R2/R3/R4/R5/R7/R9 vector");

        // R8: idle cycle after an access has no acknowledge
        @(posedge clk); @(negedge clk);
        check("R8 idle ack", 192'(ack_n), 192'(1));

        // R6: reset keeps staging latches; trigger presents them
        access(1'b0, 16, 16'h0, "R4 pass select");
        access(1'b0, 5, 16'h9876, "R2 pass write");
        do_reset();
        check("R6 mid reset codes", dac_code, exp_codes());
        access(1'b0, 7, 16'h3330, "R6 staged after reset");
        access(1'b0, 18, 16'h0, "R6 trigger after reset");

        // R7: whole calibration window
        for (int a = 32; a < 64; a++) access(1'b1, a, 16'h0, "R7 cal read");

        // R9: gap, reads of write space, writes to read window
        for (int a = 19; a < 32; a++) access(1'b0, a, 16'hFFFF, "R9 gap write");
        for (int a = 0; a < 19; a++)  access(1'b1, a, 16'h0, "R9 read of write space");
        access(1'b0, 33, 16'hFFFF, "R9 write to cal");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule